// File: doc/BRIEF.md
# Zero-Operand Instruction Skip Unit

This unit sits beside the fetch stage of a simple scalar core. It keeps one flag per architectural register that says whether the register currently holds zero. Each flag is refreshed from the register writeback port. The unit also holds a small programmable table of skip rules. Each rule names a trigger fetch address, a resume address and a condition on the zero flag of one register.

Every fetched address is looked up in the table. When a valid rule matches and its condition holds, the unit asks fetch to jump to the resume address on the following cycle. The instructions between the trigger and the resume point are then never fetched, so they are never squashed. When no rule fires, fetch continues sequentially and pays no penalty.

Rules are loaded through a register-style programming port that stands in for the instruction-set extension.

Top module: `zskip_unit`

## Requirements
- R1: After reset, every zero flag reads clear except bit 0, and `redirValid` is low. No table entry is valid, so no fetch address produces a redirect.
- R2: A writeback to register n (n ≠ 0) sets bit n of `zeroFlags` on the next cycle when `wbData` is zero. It clears that bit when `wbData` is nonzero.
- R3: Register 0 reads as zero: bit 0 of `zeroFlags` is always 1, and writebacks to register 0 have no effect on it.
- R4: A programming write (`progWe` high) changes table entry `progIdx` at the next clock edge. A lookup in the same cycle as the write still sees the old contents.
- R5: When a fetch matches a valid entry whose mode bit is 1 and whose register's flag is set, `redirValid` is 1 on the next cycle and `redirPc` equals that entry's resume address.
- R6: With mode bit 0, the entry fires only when its register's flag is clear, meaning the register is nonzero.
- R7: When the matching entry's condition fails, or no entry matches, `redirValid` is 0 on the next cycle and `redirPc` is 0.
- R8: When a writeback to the conditioned register occurs in the same cycle as the lookup, the condition uses the zero-ness of that writeback value instead of the stored flag.
- R9: When several valid entries share the trigger address, only the lowest-index entry is considered.
- R10: When `fetchValid` is low, no redirect follows, whatever `fetchPc` holds.
- R11: An entry written with `progValid` = 0 never matches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wbValid | input | 1 | Register writeback strobe |
| wbReg | input | 5 | Writeback register index |
| wbData | input | 32 | Writeback value |
| progWe | input | 1 | Table write enable |
| progIdx | input | 4 | Table entry being written |
| progValid | input | 1 | Valid bit for the written entry |
| progTrigPc | input | 32 | Trigger fetch address |
| progResumePc | input | 32 | Address fetch resumes at when the rule fires |
| progReg | input | 5 | Register whose zero flag is tested |
| progMode | input | 1 | 1: fire when the register is zero; 0: fire when it is nonzero |
| fetchValid | input | 1 | A fetch is taking place this cycle |
| fetchPc | input | 32 | Address being fetched |
| redirValid | output | 1 | Registered request to redirect the next fetch |
| redirPc | output | 32 | Registered redirect target, 0 when idle |
| zeroFlags | output | 32 | Current zero flag of every register |

## Verification
The hardest case to reach from the ports is the one where a writeback to the conditioned register lands in the same cycle as the trigger fetch, and where the value written disagrees with the stored flag. The bench drives both directions on purpose. First it fetches the trigger while writing a nonzero value over a register flagged zero, then it fetches while writing zero over a register flagged nonzero. A later random phase fetches over a small set of shared trigger addresses while writeback traffic targets the same few registers, so forwarding, priority among duplicates and mode selection keep colliding.

// File: rtl/zskip_pkg.sv
package zskip_pkg;
  typedef struct packed {
    logic redirLoad;
    logic redirClear;
  } ctrlStrb_t;
endpackage

// File: rtl/zskip_ctrl.sv
module zskip_ctrl
  import zskip_pkg::*;
#(
  parameter int NUM_ENTRIES = 16,
  localparam int IDX_W = $clog2(NUM_ENTRIES)
) (
  input  logic [NUM_ENTRIES-1:0] hitVec,
  input  logic [NUM_ENTRIES-1:0] condVec,
  output logic [IDX_W-1:0]       selIdx,
  output ctrlStrb_t              strb
);
  logic anyHit;

  always_comb begin
    selIdx = '0;
    anyHit = 1'b0;
    for (int i = NUM_ENTRIES - 1; i >= 0; i--) begin
      if (hitVec[i]) begin
        selIdx = IDX_W'(i);
        anyHit = 1'b1;
      end
    end
    strb.redirLoad  = anyHit && condVec[selIdx];
    strb.redirClear = !strb.redirLoad;
  end
endmodule

// File: rtl/zskip_datapath.sv
module zskip_datapath
  import zskip_pkg::*;
#(
  parameter int NUM_ENTRIES  = 16,
  parameter int XLEN         = 32,
  parameter int NUM_REGS     = 32,
  parameter bit HARD_ZERO_X0 = 1'b1,
  localparam int IDX_W = $clog2(NUM_ENTRIES),
  localparam int REG_W = $clog2(NUM_REGS)
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   wbValid,
  input  logic [REG_W-1:0]       wbReg,
  input  logic [XLEN-1:0]        wbData,
  input  logic                   progWe,
  input  logic [IDX_W-1:0]       progIdx,
  input  logic                   progValid,
  input  logic [XLEN-1:0]        progTrigPc,
  input  logic [XLEN-1:0]        progResumePc,
  input  logic [REG_W-1:0]       progReg,
  input  logic                   progMode,
  input  logic                   fetchValid,
  input  logic [XLEN-1:0]        fetchPc,
  input  logic [IDX_W-1:0]       selIdx,
  input  ctrlStrb_t              strb,
  output logic [NUM_ENTRIES-1:0] hitVec,
  output logic [NUM_ENTRIES-1:0] condVec,
  output logic [NUM_REGS-1:0]    zeroFlags,
  output logic                   redirValid,
  output logic [XLEN-1:0]        redirPc
);
  logic [NUM_ENTRIES-1:0] entValid;
  logic [XLEN-1:0]        entTrig   [NUM_ENTRIES];
  logic [XLEN-1:0]        entResume [NUM_ENTRIES];
  logic [REG_W-1:0]       entReg    [NUM_ENTRIES];
  logic [NUM_ENTRIES-1:0] entMode;
  logic [NUM_REGS-1:0]    flagQ;
  logic                   wbTakes;
  logic                   wbIsZero;

  assign wbTakes  = wbValid && (!HARD_ZERO_X0 || wbReg != '0);
  assign wbIsZero = (wbData == '0);

  // Per-register zero tracking
  always_ff @(posedge clk) begin
    if (!rstN) flagQ <= '0;
    else if (wbTakes) flagQ[wbReg] <= wbIsZero;
  end

  generate
    if (HARD_ZERO_X0) begin : g_x0
      assign zeroFlags = {flagQ[NUM_REGS-1:1], 1'b1};
    end else begin : g_nox0
      assign zeroFlags = flagQ;
    end
  endgenerate

  // Rule table storage
  always_ff @(posedge clk) begin
    if (!rstN) begin
      entValid <= '0;
      entMode  <= '0;
      for (int i = 0; i < NUM_ENTRIES; i++) begin
        entTrig[i]   <= '0;
        entResume[i] <= '0;
        entReg[i]    <= '0;
      end
    end else if (progWe) begin
      entValid[progIdx]  <= progValid;
      entMode[progIdx]   <= progMode;
      entTrig[progIdx]   <= progTrigPc;
      entResume[progIdx] <= progResumePc;
      entReg[progIdx]    <= progReg;
    end
  end

  // Per-entry match and condition with writeback forwarding
  generate
    for (genvar e = 0; e < NUM_ENTRIES; e++) begin : g_ent
      logic fwd;
      logic flagNow;
      assign fwd       = wbTakes && (wbReg == entReg[e]);
      assign flagNow   = fwd ? wbIsZero : zeroFlags[entReg[e]];
      assign hitVec[e] = fetchValid && entValid[e] && (entTrig[e] == fetchPc);
      assign condVec[e] = entMode[e] ? flagNow : !flagNow;
    end
  endgenerate

  // Registered redirect
  always_ff @(posedge clk) begin
    if (!rstN) begin
      redirValid <= 1'b0;
      redirPc    <= '0;
    end else if (strb.redirLoad) begin
      redirValid <= 1'b1;
      redirPc    <= entResume[selIdx];
    end else if (strb.redirClear) begin
      redirValid <= 1'b0;
      redirPc    <= '0;
    end
  end
endmodule

// File: rtl/zskip_unit.sv
module zskip_unit
  import zskip_pkg::*;
#(
  parameter int NUM_ENTRIES  = 16,
  parameter int XLEN         = 32,
  parameter int NUM_REGS     = 32,
  parameter bit HARD_ZERO_X0 = 1'b1,
  localparam int IDX_W = $clog2(NUM_ENTRIES),
  localparam int REG_W = $clog2(NUM_REGS)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                wbValid,
  input  logic [REG_W-1:0]    wbReg,
  input  logic [XLEN-1:0]     wbData,
  input  logic                progWe,
  input  logic [IDX_W-1:0]    progIdx,
  input  logic                progValid,
  input  logic [XLEN-1:0]     progTrigPc,
  input  logic [XLEN-1:0]     progResumePc,
  input  logic [REG_W-1:0]    progReg,
  input  logic                progMode,
  input  logic                fetchValid,
  input  logic [XLEN-1:0]     fetchPc,
  output logic                redirValid,
  output logic [XLEN-1:0]     redirPc,
  output logic [NUM_REGS-1:0] zeroFlags
);
  logic [NUM_ENTRIES-1:0] hitVec;
  logic [NUM_ENTRIES-1:0] condVec;
  logic [IDX_W-1:0]       selIdx;
  ctrlStrb_t              strb;

  zskip_ctrl #(.NUM_ENTRIES(NUM_ENTRIES)) u_ctrl (
    .hitVec(hitVec), .condVec(condVec), .selIdx(selIdx), .strb(strb)
  );

  zskip_datapath #(
    .NUM_ENTRIES(NUM_ENTRIES), .XLEN(XLEN), .NUM_REGS(NUM_REGS),
    .HARD_ZERO_X0(HARD_ZERO_X0)
  ) u_dp (
    .clk(clk), .rstN(rstN),
    .wbValid(wbValid), .wbReg(wbReg), .wbData(wbData),
    .progWe(progWe), .progIdx(progIdx), .progValid(progValid),
    .progTrigPc(progTrigPc), .progResumePc(progResumePc),
    .progReg(progReg), .progMode(progMode),
    .fetchValid(fetchValid), .fetchPc(fetchPc),
    .selIdx(selIdx), .strb(strb),
    .hitVec(hitVec), .condVec(condVec), .zeroFlags(zeroFlags),
    .redirValid(redirValid), .redirPc(redirPc)
  );
endmodule

// File: rtl/zskip_checker.sv
module zskip_checker #(
  parameter int XLEN         = 32,
  parameter int NUM_REGS     = 32,
  parameter bit HARD_ZERO_X0 = 1'b1,
  localparam int REG_W = $clog2(NUM_REGS)
) (
  input logic                clk,
  input logic                rstN,
  input logic                wbValid,
  input logic [REG_W-1:0]    wbReg,
  input logic [XLEN-1:0]     wbData,
  input logic                fetchValid,
  input logic                redirValid,
  input logic [XLEN-1:0]     redirPc,
  input logic [NUM_REGS-1:0] zeroFlags
);
  AST_FLAG_TRACK: assert property (@(posedge clk) disable iff (!rstN)
    (wbValid && wbReg != '0) |=> zeroFlags[$past(wbReg)] == ($past(wbData) == '0)); // R2

  AST_X0_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    !HARD_ZERO_X0 || zeroFlags[0]); // R3

  AST_IDLE_PC: assert property (@(posedge clk) disable iff (!rstN)
    !redirValid |-> redirPc == '0); // R7

  AST_NO_FETCH_NO_REDIR: assert property (@(posedge clk) disable iff (!rstN)
    !fetchValid |=> !redirValid); // R10
endmodule

bind zskip_unit zskip_checker #(
  .XLEN(XLEN), .NUM_REGS(NUM_REGS), .HARD_ZERO_X0(HARD_ZERO_X0)
) u_chk (
  .clk(clk), .rstN(rstN), .wbValid(wbValid), .wbReg(wbReg), .wbData(wbData),
  .fetchValid(fetchValid), .redirValid(redirValid), .redirPc(redirPc),
  .zeroFlags(zeroFlags)
);

// File: tb/zskip_unit_bench.sv
`timescale 1ns/1ps
module zskip_unit_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wbValid = 1'b0;
  logic [4:0]  wbReg = '0;
  logic [31:0] wbData = '0;
  logic        progWe = 1'b0;
  logic [3:0]  progIdx = '0;
  logic        progValid = 1'b0;
  logic [31:0] progTrigPc = '0;
  logic [31:0] progResumePc = '0;
  logic [4:0]  progReg = '0;
  logic        progMode = 1'b0;
  logic        fetchValid = 1'b0;
  logic [31:0] fetchPc = '0;
  logic        redirValid;
  logic [31:0] redirPc;
  logic [31:0] zeroFlags;

  always #4 clk = ~clk;

  zskip_unit u_zskip_unit (.*);

  int errors = 0;
  int checks = 0;

  // Reference model state
  bit          mValid [16];
  bit [31:0]   mTrig [16];
  bit [31:0]   mResume [16];
  bit [4:0]    mReg [16];
  bit          mMode [16];
  bit [31:0]   mFlags;
  bit          eRedir;
  bit [31:0]   ePc;

  task automatic check(string tag, bit ok, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic bit flagOf(int r);
    if (r == 0) return 1'b1;
    return mFlags[r];
  endfunction

  // Advance one clock with the inputs currently driven, then compare.
  task automatic step(string tag);
    int hitIdx = -1;
    bit f;
    for (int i = 0; i < 16; i++) begin
      if (hitIdx < 0 && fetchValid && mValid[i] && mTrig[i] == fetchPc) hitIdx = i;
    end
    eRedir = 1'b0;
    ePc = '0;
    if (hitIdx >= 0) begin
      if (wbValid && wbReg != 0 && wbReg == mReg[hitIdx]) f = (wbData == 0);
      else f = flagOf(int'(mReg[hitIdx]));
      if (mMode[hitIdx] ? f : !f) begin
        eRedir = 1'b1;
        ePc = mResume[hitIdx];
      end
    end
    if (wbValid && wbReg != 0) mFlags[wbReg] = (wbData == 0);
    mFlags[0] = 1'b1;
    if (progWe) begin
      mValid[progIdx] = progValid;
      mTrig[progIdx] = progTrigPc;
      mResume[progIdx] = progResumePc;
      mReg[progIdx] = progReg;
      mMode[progIdx] = progMode;
    end
    @(posedge clk);
    @(negedge clk);
    check(tag, redirValid == eRedir, "redirValid", 32'(redirValid), 32'(eRedir));
    check(tag, redirPc == ePc, "redirPc", redirPc, ePc);
    check("R2", zeroFlags == mFlags, "zeroFlags", zeroFlags, mFlags);
    wbValid = 1'b0;
    progWe = 1'b0;
    fetchValid = 1'b0;
  endtask

  task automatic wb(int r, logic [31:0] d);
    wbValid = 1'b1; wbReg = 5'(r); wbData = d;
  endtask

  task automatic prog(int idx, bit v, logic [31:0] t, logic [31:0] res, int r, bit m);
    progWe = 1'b1; progIdx = 4'(idx); progValid = v; progTrigPc = t;
    progResumePc = res; progReg = 5'(r); progMode = m;
  endtask

  task automatic fetch(logic [31:0] pc);
    fetchValid = 1'b1; fetchPc = pc;
  endtask

  initial begin
    #(8ns * 150000);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < 16; i++) begin
      mValid[i] = 0; mTrig[i] = 0; mResume[i] = 0; mReg[i] = 0; mMode[i] = 0;
    end
    mFlags = 32'h1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    // R1: reset state
    check("R1", zeroFlags == 32'h1, "zeroFlags", zeroFlags, 32'h1);
    check("R1", redirValid == 1'b0, "redirValid", 32'(redirValid), 32'h0);
    fetch(32'h0); step("R1");
    // R2: set then clear
    wb(5, 0); step("R2");
    wb(5, 7); step("R2");
    // R3: x0 writes ignored
    wb(0, 32'h5); step("R3");
    check("R3", zeroFlags[0] == 1'b1, "x0 flag", 32'(zeroFlags[0]), 32'h1);
    // R4: write and lookup same cycle sees old table
    prog(2, 1, 32'h100, 32'h120, 5, 1); fetch(32'h100); wb(5, 0); step("R4");
    // R7: condition fails (x5 nonzero)
    wb(5, 9); step("R2");
    fetch(32'h100); step("R7");
    // R5: condition holds
    wb(5, 0); step("R2");
    fetch(32'h100); step("R5");
    // R6: mode 0 fires on nonzero
    prog(3, 1, 32'h200, 32'h240, 6, 0); wb(6, 9); step("R6");
    fetch(32'h200); step("R6");
    wb(6, 0); step("R6");
    fetch(32'h200); step("R6");
    // R8: forwarding both directions
    fetch(32'h100); wb(5, 3); step("R8");
    fetch(32'h100); wb(5, 0); step("R8");
    // R9: lowest index wins
    prog(1, 1, 32'h100, 32'h180, 0, 1); step("R9");
    fetch(32'h100); step("R9");
    // R10: no fetch, no redirect
    fetchPc = 32'h100; step("R10");
    // R11: invalidated entry ignored, falls to entry 2
    prog(1, 0, 32'h100, 32'h180, 0, 1); step("R11");
    fetch(32'h100); step("R11");
    // Random collisions over a small address/register set
    for (int n = 0; n < 400; n++) begin
      int k = $urandom_range(0, 9);
      if (k < 2) prog($urandom_range(0, 15), $urandom_range(0, 3) != 0,
                      32'h100 + 32'($urandom_range(0, 3)) * 32'h10,
                      32'($urandom_range(0, 65535)) << 2,
                      $urandom_range(0, 3), $urandom_range(0, 1));
      if (k != 3) wb($urandom_range(0, 3), $urandom_range(0, 1) ? 32'h0 : 32'($urandom_range(1, 99)));
      if (k > 1) fetch(32'h100 + 32'($urandom_range(0, 3)) * 32'h10);
      step("R5");
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule